// File: doc/BRIEF.md
# Flag-Conditioned Branching Program Counter

This block produces the address of the next instruction for a small accumulator-style CPU. It holds a program counter and updates it on every clock edge. Reset restarts the program at address zero. Otherwise the counter either loads a jump target taken from the address register or steps forward by one.

The choice depends on a three-bit branch mask taken from the low bits of the current instruction. The block compares that mask with three conditions that it derives from the ALU's zero and negative flags: below zero, equal to zero and above zero. If any enabled condition holds, the branch is taken. Branching is only possible for compute instructions. A literal instruction always steps forward, whatever its low bits carry.

The counter is 15 bits wide and wraps around. Only the low 15 bits of the 16-bit target are loaded.

Top module: `branch_pc`

## Requirements
- R1: When `rst` is high at a rising clock edge, `pc_q` becomes 0 after that edge, even if a branch would otherwise be taken.
- R2: Mask bit 2 enables a branch on a result below zero (`neg_flag`=1). Bit 1 enables it on a result equal to zero (`zero_flag`=1). Bit 0 enables it on a result above zero.
- R3: The above-zero condition holds exactly when `zero_flag`=0 and `neg_flag`=0.
- R4: Mask 3'b000 never branches. Mask 3'b111 always branches on a compute instruction, whatever the flags are.
- R5: When `is_compute`=0 (literal instruction), no branch is taken for any mask or flag value, and the counter increments.
- R6: On a taken branch, `pc_q` becomes `target[14:0]` after the edge. `target[15]` has no effect.
- R7: When no branch is taken and reset is low, `pc_q` becomes `pc_q`+1 after the edge, and 15'h7FFF wraps to 0.
- R8: Combined masks branch when any of their enabled conditions holds: 3'b011 on above or equal, 3'b101 on not equal, and 3'b110 on below or equal.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous restart, highest priority |
| is_compute | input | 1 | 1 for a compute instruction, 0 for a literal instruction |
| jmp_mask | input | 3 | Branch mask: bit 2 below, bit 1 equal, bit 0 above zero |
| zero_flag | input | 1 | ALU result equals zero |
| neg_flag | input | 1 | ALU result is negative |
| target | input | 16 | Jump target from the address register |
| pc_q | output | 15 | Current program counter |

## Verification
The bench sweeps all eight masks against the below, equal and above flag states. A design that swapped the outer mask bits, or took the above-zero condition as simply "not zero", would branch on the wrong sign. Literal instructions with an all-ones mask are driven to catch a branch that ignores the instruction type. A target with bit 15 set, and a counter parked at 15'h7FFF, expose a design that keeps the top target bit or fails to wrap. Reset is applied together with a taken branch to show that reset wins over the load.

// File: rtl/branch_pc_pkg.sv
package branch_pc_pkg;
  localparam int PC_W   = 15;
  localparam int DATA_W = 16;
  localparam int MASK_W = 3;

  typedef logic [PC_W-1:0]   pc_t;
  typedef logic [MASK_W-1:0] mask_t;

  // Condition vector aligned with the mask: [2]=below, [1]=equal, [0]=above
  function automatic mask_t flag_conditions(input logic zero, input logic neg);
    mask_t c;
    c[2] = neg;
    c[1] = zero;
    c[0] = ~zero & ~neg;
    return c;
  endfunction

  function automatic pc_t pc_increment(input pc_t cur);
    return cur + pc_t'(1);
  endfunction
endpackage

// File: rtl/branch_cond.sv
module branch_cond
  import branch_pc_pkg::*;
#(
  parameter int N_COND = MASK_W
) (
  input  logic [N_COND-1:0] mask,
  input  logic              zero,
  input  logic              neg,
  input  logic              compute,
  output logic [N_COND-1:0] hits,
  output logic              take
);
  logic [N_COND-1:0] cond;

  always_comb cond = flag_conditions(zero, neg);

  for (genvar i = 0; i < N_COND; i++) begin : g_match
    assign hits[i] = mask[i] & cond[i];
  end

  assign take = compute & (|hits);
endmodule

// File: rtl/pc_step.sv
module pc_step
  import branch_pc_pkg::*;
#(
  parameter int AW = PC_W,
  parameter int TW = DATA_W
) (
  input  logic          restart,
  input  logic          load,
  input  logic [TW-1:0] dest,
  input  logic [AW-1:0] cur,
  output logic [AW-1:0] nxt
);
  localparam logic [AW-1:0] START = '0;

  always_comb begin
    if (restart)   nxt = START;
    else if (load) nxt = dest[AW-1:0];
    else           nxt = cur + AW'(1);
  end
endmodule

// File: rtl/branch_pc.sv
module branch_pc
  import branch_pc_pkg::*;
#(
  parameter int AW = PC_W,
  parameter int TW = DATA_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          is_compute,
  input  logic [2:0]    jmp_mask,
  input  logic          zero_flag,
  input  logic          neg_flag,
  input  logic [TW-1:0] target,
  output logic [AW-1:0] pc_q
);
  logic [2:0]    cond_hits;
  logic          branch_taken;
  logic [AW-1:0] pc_d;

  branch_cond #(.N_COND(3)) u_cond (
    .mask    (jmp_mask),
    .zero    (zero_flag),
    .neg     (neg_flag),
    .compute (is_compute),
    .hits    (cond_hits),
    .take    (branch_taken)
  );

  pc_step #(.AW(AW), .TW(TW)) u_step (
    .restart (rst),
    .load    (branch_taken),
    .dest    (target),
    .cur     (pc_q),
    .nxt     (pc_d)
  );

  always_ff @(posedge clk) pc_q <= pc_d;
endmodule

// File: rtl/branch_pc_chk.sv
module branch_pc_chk #(
  parameter int AW = 15,
  parameter int TW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          is_compute,
  input logic [2:0]    jmp_mask,
  input logic [TW-1:0] target,
  input logic          branch_taken,
  input logic [AW-1:0] pc_q
);
  assert_restart_R1: assert property (@(posedge clk)
    rst |=> pc_q == '0);

  assert_literal_no_branch_R5: assert property (@(posedge clk) disable iff (rst)
    !is_compute |-> !branch_taken);

  assert_empty_mask_R4: assert property (@(posedge clk) disable iff (rst)
    jmp_mask == 3'b000 |-> !branch_taken);

  assert_full_mask_R4: assert property (@(posedge clk) disable iff (rst)
    (is_compute && jmp_mask == 3'b111) |-> branch_taken);

  assert_load_target_R6: assert property (@(posedge clk) disable iff (rst)
    branch_taken |=> pc_q == $past(target[AW-1:0]));

  assert_increment_R7: assert property (@(posedge clk) disable iff (rst)
    !branch_taken |=> pc_q == AW'($past(pc_q) + AW'(1)));
endmodule

bind branch_pc branch_pc_chk #(.AW(AW), .TW(TW)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .is_compute   (is_compute),
  .jmp_mask     (jmp_mask),
  .target       (target),
  .branch_taken (branch_taken),
  .pc_q         (pc_q)
);

// File: tb/sim_branch_pc.sv
`timescale 1ns/1ps
module sim_branch_pc;
  logic        clk = 1'b0;
  logic        rst;
  logic        is_compute;
  logic [2:0]  jmp_mask;
  logic        zero_flag;
  logic        neg_flag;
  logic [15:0] target;
  logic [14:0] pc_q;

  int checks = 0;
  int errors = 0;
  logic [14:0] model_pc;

  always #5 clk = ~clk;

  branch_pc u0 (
    .clk(clk), .rst(rst), .is_compute(is_compute), .jmp_mask(jmp_mask),
    .zero_flag(zero_flag), .neg_flag(neg_flag), .target(target), .pc_q(pc_q)
  );

  // Bench view of the branch rule, written from the requirements
  function automatic bit bench_branch(bit comp, bit [2:0] m, bit z, bit n);
    bit below, equal, above;
    below = n;
    equal = z;
    above = !(z || n);
    if (!comp) return 0;
    return (m[2] && below) || (m[1] && equal) || (m[0] && above);
  endfunction

  function automatic logic [14:0] bench_next(bit r, bit br, logic [15:0] t, logic [14:0] p);
    if (r) return 15'd0;
    if (br) return t[14:0];
    return (p == 15'h7FFF) ? 15'd0 : p + 15'd1;
  endfunction

  task automatic check(string req, logic [14:0] got, logic [14:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: pc_q=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic step(string req, bit r, bit comp, bit [2:0] m, bit z, bit n, logic [15:0] t);
    rst = r; is_compute = comp; jmp_mask = m; zero_flag = z; neg_flag = n; target = t;
    model_pc = bench_next(r, bench_branch(comp, m, z, n), t, model_pc);
    @(posedge clk);
    #1;
    check(req, pc_q, model_pc);
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: run hung, pc_q=%h expected=%h", pc_q, model_pc);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst = 1; is_compute = 0; jmp_mask = 0; zero_flag = 0; neg_flag = 0; target = 0;
    model_pc = 0;
    @(posedge clk); #1;
    step("R1 reset state", 1, 0, 3'b000, 0, 0, 16'h0);
    // R2 R3 R4 R8: all masks against below / equal / above
    for (int m = 0; m < 8; m++) begin
      for (int f = 0; f < 3; f++) begin
        step("R2 R3 R4 R8 mask sweep", 0, 1, 3'(m), f == 1, f == 0,
             16'h0100 + 16'(m * 3 + f));
      end
    end
    // R2 both flags set: below and equal both hold
    step("R2 both flags, mask 001", 0, 1, 3'b001, 1, 1, 16'h0222);
    step("R2 both flags, mask 100", 0, 1, 3'b100, 1, 1, 16'h0333);
    // R5 literal never branches
    step("R5 literal with 111", 0, 0, 3'b111, 0, 1, 16'h0444);
    step("R5 literal with 010", 0, 0, 3'b010, 1, 0, 16'h0555);
    // R6 top bit of target ignored
    step("R6 target bit15 dropped", 0, 1, 3'b111, 0, 0, 16'hFFFF);
    // R7 wrap from 7FFF
    step("R7 wrap to zero", 0, 1, 3'b000, 0, 0, 16'h1234);
    step("R7 increment after wrap", 0, 0, 3'b111, 0, 0, 16'h1234);
    // R1 reset beats a taken branch
    step("R6 load before reset", 0, 1, 3'b111, 1, 0, 16'h0ABC);
    step("R1 reset over branch", 1, 1, 3'b111, 1, 0, 16'h0DEF);
    // Constrained random mix
    void'($urandom(32'd1357));
    for (int i = 0; i < 400; i++) begin
      bit r, comp, z, n;
      bit [2:0] m;
      logic [15:0] t;
      r    = ($urandom % 32) == 0;
      comp = ($urandom % 4) != 0;
      m    = 3'($urandom);
      z    = ($urandom % 3) == 0;
      n    = z ? (($urandom % 8) == 0) : 1'($urandom);
      t    = 16'($urandom);
      step("R1 R5 R6 R7 R8 random", r, comp, m, z, n, t);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule